// File: doc/BRIEF.md
# Triggered One-Shot Output Stage

This block sits between a timer's raw compare output and one pulse-generator pin. It produces the pin data value and the pin output-enable. In plain mode the pin follows the compare output. In one-shot mode a trigger event opens a window that stays active for a programmable number of time-base periods, and the compare output is not used.

Three further controls act on the path. The first is a polarity select that chooses the active level. The second is a triggered-mode gate: it can keep the pin undriven until the first trigger has been seen. The third is an external shutdown input that forces one of three safe states for as long as it is held. All configuration fields are static inputs. The window state and the trigger flag are registered, and the final output mux is combinational.

Top module: `oneshot_out_stage`

## Requirements
- R1: With one-shot mode off, no shutdown and no gating, `pin_o` equals `cmp_i` XOR `pol_low_i` and `pin_oe_o` is 1. `ext_cnt_i` and `trig_i` have no effect on the pin.
- R2: With one-shot mode on, `trig_i` opens the window from the next cycle, and the pin is driven active. Each `tick_i` seen while the window is open counts down from `ext_cnt_i` = N. The window closes on the (N+1)-th tick, and the pin is inactive from the following cycle. `cmp_i` is ignored.
- R3: With N = 0 the window closes on the first tick after the trigger.
- R4: A trigger that arrives while the window is open reloads the count to N.
- R5: When `trig_i` and `tick_i` arrive in the same cycle, the trigger wins. The count is reloaded and that tick is not counted.
- R6: When `trig_mode_i` = 1, `oe_on_trig_i` = 1 and no trigger has yet been seen in triggered mode, `pin_oe_o` is 0 and `pin_o` is at the inactive level. The cycle after a trigger, the pin is driven normally.
- R7: With `oe_on_trig_i` = 0, triggered mode does not gate the pin.
- R8: Setting `trig_mode_i` to 0 clears the seen-trigger flag. Gating then applies again when triggered mode is next enabled.
- R9: `pol_low_i` = 1 makes the pin active-low, so a logical active level drives 0 and the inactive level is 1. With 0 the pin is active-high.
- R10: While `shdn_i` = 1, the code `shdn_state_i` = 2'b11 drives the pin to its active level and code 2'b10 drives it to its inactive level. In both cases `pin_oe_o` = 1 and the polarity setting applies.
- R11: While `shdn_i` = 1, codes 2'b00 and 2'b01 set `pin_oe_o` = 0, and `pin_o` is held at the inactive level.
- R12: Shutdown takes priority over the normal path and over the trigger-wait gating.
- R13: After reset the window is closed and the seen-trigger flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Raw compare output from the timer (logical active = 1) |
| trig_i | input | 1 | Trigger event, one-cycle pulse |
| tick_i | input | 1 | Time-base period tick, one-cycle pulse |
| oneshot_en_i | input | 1 | One-shot mode enable |
| trig_mode_i | input | 1 | Triggered mode enable |
| oe_on_trig_i | input | 1 | Hold the pin undriven until a trigger (triggered mode only) |
| ext_cnt_i | input | 3 | One-shot extension count N |
| pol_low_i | input | 1 | 1: active-low pin, 0: active-high pin |
| shdn_i | input | 1 | External shutdown request |
| shdn_state_i | input | 2 | Shutdown pin state code |
| pin_o | output | 1 | Pin data value |
| pin_oe_o | output | 1 | Pin output-enable |

## Verification
The assertions assume several things about the inputs. `trig_i` and `tick_i` are single-cycle pulses that are synchronous to `clk_i`. The configuration fields change only between cycles and never within one. `ext_cnt_i` is taken as stable while a window is open.

The stimulus changes every input on the falling edge and samples the outputs one time unit later. It changes configuration only between test phases, and it raises `trig_i` and `tick_i` together only in the directed case that covers the same-cycle collision.

// File: rtl/oneshot_out_pkg.sv
package oneshot_out_pkg;
  typedef enum logic [1:0] {
    SD_HIZ0  = 2'b00,
    SD_HIZ1  = 2'b01,
    SD_INACT = 2'b10,
    SD_ACT   = 2'b11
  } sd_code_e;

  localparam int unsigned CNT_W = 3;
endpackage

// File: rtl/os_window.sv
module os_window #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             open_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig_i) begin
      // trigger wins over a coincident tick
      open_q <= 1'b1;
      cnt_q  <= load_i;
    end else if (open_q && tick_i) begin
      if (cnt_q == '0) open_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign open_o = open_q;

  assert_trig_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && trig_i) |=> open_o);
  assert_hold_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && open_o && !tick_i && !trig_i) |=> open_o);
  assert_idle_stays_closed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && !trig_i) |=> !open_o);
endmodule

// File: rtl/trig_gate.sv
module trig_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic oe_on_trig_i,
  input  logic trig_i,
  output logic gate_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_q <= 1'b0;
    else if (!mode_i) seen_q <= 1'b0;
    else if (trig_i)  seen_q <= 1'b1;
  end

  assign gate_o = mode_i & oe_on_trig_i & ~seen_q;

  assert_release_after_trig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && trig_i) |=> !gate_o);
  assert_mode_off_rearms_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i) |=> (gate_o == (mode_i && oe_on_trig_i)));
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import oneshot_out_pkg::*;
(
  input  logic       act_i,
  input  logic       pol_low_i,
  input  logic       gate_i,
  input  logic       shdn_i,
  input  logic [1:0] shdn_state_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  logic inact_lvl;
  assign inact_lvl = pol_low_i;

  always_comb begin
    pin_o    = act_i ^ pol_low_i;
    pin_oe_o = 1'b1;
    if (shdn_i) begin
      unique case (sd_code_e'(shdn_state_i))
        SD_ACT:   pin_o = ~inact_lvl;
        SD_INACT: pin_o = inact_lvl;
        default: begin
          pin_o    = inact_lvl;
          pin_oe_o = 1'b0;
        end
      endcase
    end else if (gate_i) begin
      pin_o    = inact_lvl;
      pin_oe_o = 1'b0;
    end
  end
endmodule

// File: rtl/oneshot_out_stage.sv
module oneshot_out_stage
  import oneshot_out_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic             oneshot_en_i,
  input  logic             trig_mode_i,
  input  logic             oe_on_trig_i,
  input  logic [CNT_W-1:0] ext_cnt_i,
  input  logic             pol_low_i,
  input  logic             shdn_i,
  input  logic [1:0]       shdn_state_i,
  output logic             pin_o,
  output logic             pin_oe_o
);
  logic win_open, gate, act;

  os_window #(.CNT_W(CNT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (oneshot_en_i),
    .trig_i (trig_i),
    .tick_i (tick_i),
    .load_i (ext_cnt_i),
    .open_o (win_open)
  );

  trig_gate u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (trig_mode_i),
    .oe_on_trig_i (oe_on_trig_i),
    .trig_i       (trig_i),
    .gate_o       (gate)
  );

  assign act = oneshot_en_i ? win_open : cmp_i;

  pin_mux u_mux (
    .act_i        (act),
    .pol_low_i    (pol_low_i),
    .gate_i       (gate),
    .shdn_i       (shdn_i),
    .shdn_state_i (shdn_state_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o)
  );

  assert_plain_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oneshot_en_i && !shdn_i && !gate) |-> (pin_oe_o && pin_o == (cmp_i ^ pol_low_i)));
  assert_gate_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate && !shdn_i) |-> (!pin_oe_o && pin_o == pol_low_i));
  assert_sd_forced_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_i && shdn_state_i[1]) |-> (pin_oe_o && pin_o == (shdn_state_i[0] ^ pol_low_i)));
  assert_sd_hiz_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_i && !shdn_state_i[1]) |-> (!pin_oe_o && pin_o == pol_low_i));
endmodule

// File: tb/sim_oneshot_out_stage.sv
`timescale 1ns/1ps
module sim_oneshot_out_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 0, trig = 0, tick = 0, os_en = 0, tmode = 0, oe_on = 0, pol = 0, shdn = 0;
  logic [2:0] ext = 0;
  logic [1:0] sd = 0;
  logic pin, oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  oneshot_out_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp), .trig_i(trig), .tick_i(tick),
    .oneshot_en_i(os_en), .trig_mode_i(tmode), .oe_on_trig_i(oe_on),
    .ext_cnt_i(ext), .pol_low_i(pol), .shdn_i(shdn), .shdn_state_i(sd),
    .pin_o(pin), .pin_oe_o(oe)
  );

  // {cmp, pol, shdn, sd[1:0], exp_pin, exp_oe}
  localparam logic [6:0] VEC [11] = '{
    7'b0_0_0_00_0_1, // R1
    7'b1_0_0_00_1_1, // R1
    7'b1_1_0_00_0_1, // R9
    7'b0_1_0_00_1_1, // R9
    7'b1_0_1_11_1_1, // R10
    7'b0_0_1_11_1_1, // R10
    7'b0_1_1_11_0_1, // R10
    7'b1_0_1_10_0_1, // R10
    7'b1_1_1_10_1_1, // R10
    7'b1_0_1_00_0_0, // R11
    7'b1_1_1_01_1_0  // R11
  };

  task automatic chk(input string req, input logic ep, input logic eo);
    #1;
    checks++;
    if (pin !== ep || oe !== eo) begin
      errors++;
      $display("FAIL %s: pin=%b oe=%b expected pin=%b oe=%b", req, pin, oe, ep, eo);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_trig(); trig = 1; cyc(); trig = 0; endtask
  task automatic pulse_tick(); tick = 1; cyc(); tick = 0; endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc();
    rst_n = 1;
    @(negedge clk);
    // R13: reset leaves window closed and flag clear
    os_en = 1;
    chk("R13 window closed", 1'b0, 1'b1);
    os_en = 0; tmode = 1; oe_on = 1;
    chk("R13 flag clear", 1'b0, 1'b0);
    tmode = 0; oe_on = 0;

    for (int i = 0; i < 11; i++) begin
      {cmp, pol, shdn, sd} = VEC[i][6:2];
      chk($sformatf("R1/R9/R10/R11 vec %0d", i), VEC[i][1], VEC[i][0]);
    end
    shdn = 0; sd = 0; pol = 0;

    // R1: count and trigger ignored with one-shot off
    ext = 3'd7; cmp = 0;
    pulse_trig(); chk("R1 trig ignored", 1'b0, 1'b1);
    cmp = 1; pulse_tick(); chk("R1 follows cmp", 1'b1, 1'b1);
    cmp = 0;

    // R2: N=2, window closes on third tick
    os_en = 1; ext = 3'd2; cmp = 1;
    chk("R2 idle ignores cmp", 1'b0, 1'b1);
    pulse_trig(); chk("R2 open", 1'b1, 1'b1);
    pulse_tick(); chk("R2 tick1", 1'b1, 1'b1);
    cyc(); chk("R2 no tick hold", 1'b1, 1'b1);
    pulse_tick(); chk("R2 tick2", 1'b1, 1'b1);
    pulse_tick(); chk("R2 tick3 closed", 1'b0, 1'b1);
    cmp = 0;

    // R3: N=0
    ext = 3'd0;
    pulse_trig(); chk("R3 open", 1'b1, 1'b1);
    pulse_tick(); chk("R3 closed", 1'b0, 1'b1);

    // R4: retrigger reload, N=1
    ext = 3'd1;
    pulse_trig(); pulse_tick(); chk("R4 after tick1", 1'b1, 1'b1);
    pulse_trig(); pulse_tick(); chk("R4 reloaded", 1'b1, 1'b1);
    pulse_tick(); chk("R4 closed", 1'b0, 1'b1);

    // R5: trigger with tick same cycle, N=0
    ext = 3'd0;
    pulse_trig();
    trig = 1; tick = 1; cyc(); trig = 0; tick = 0;
    chk("R5 trig wins", 1'b1, 1'b1);
    pulse_tick(); chk("R5 closed", 1'b0, 1'b1);

    // R9 in one-shot: active-low
    pol = 1; chk("R9 idle high", 1'b1, 1'b1);
    pulse_trig(); chk("R9 active low", 1'b0, 1'b1);
    pulse_tick(); pol = 0; os_en = 0;

    // R6: gating
    tmode = 1; oe_on = 1; cmp = 1;
    cyc(); chk("R6 gated", 1'b0, 1'b0);
    pol = 1; chk("R6 gated inactive low-pol", 1'b1, 1'b0);
    pol = 0;
    // R12: shutdown beats gating
    shdn = 1; sd = 2'b11; chk("R12 sd active over gate", 1'b1, 1'b1);
    sd = 2'b10; chk("R12 sd inactive over gate", 1'b0, 1'b1);
    shdn = 0; sd = 0;
    pulse_trig(); chk("R6 released", 1'b1, 1'b1);
    // R8
    tmode = 0; cyc(); tmode = 1;
    chk("R8 regated", 1'b0, 1'b0);
    // R7
    oe_on = 0; chk("R7 no gating", 1'b1, 1'b1);
    oe_on = 1; shdn = 1; sd = 2'b01;
    chk("R12 sd hiz", 1'b0, 1'b0);
    shdn = 0; sd = 0; tmode = 0; oe_on = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule